// File: doc/BRIEF.md
# Reversing Two-Byte Seven-Segment Display Encoder

This block drives four seven-segment digits from two 8-bit binary values, a high value and a low value. It shows the tens and units of each. A timer core that can only count upward feeds it elapsed minutes (high) and elapsed seconds (low). A single mode input selects how the display reads. With the mode low, the elapsed value is shown as it is and the display rises. With the mode high, an internal reverser turns the elapsed time into the time left from a two-minute start, so the display falls while the input still rises.

The block has no clock and no state, and every output is a function of the present inputs. After the optional reversal, each byte is converted to decimal by the shift-and-add-3 method. Each decimal digit is then mapped to an active-low segment pattern. A byte whose value after reversal exceeds 99 is shown as two dashes.

Top module: `revseg_display`

## Requirements
- R1: With `count_down` low, the high pair shows the tens and units of `hi_bin`, and the low pair shows the tens and units of `lo_bin`.
- R2: With `count_down` high and `lo_bin` equal to 0, the low pair shows 00 and the high pair shows 2 minus `hi_bin`, computed modulo 256.
- R3: With `count_down` high and `lo_bin` non-zero, the low pair shows 60 minus `lo_bin` and the high pair shows 1 minus `hi_bin`, both computed modulo 256.
- R4: With `count_down` high and both inputs zero, the four digits read 0, 2, 0, 0.
- R5: A pair whose value after reversal is above 99 shows a dash on both of its digits. A dash has only segment g lit (code 7'b0111111). The other pair is not affected.
- R6: Segment outputs are active-low, with bit 0 driving segment a up to bit 6 driving segment g. The digits 0 to 9 use the codes 40, 79, 24, 30, 19, 12, 02, 78, 00 and 10 (hex).
- R7: A tens digit of zero is shown as the digit 0, not blanked.
- R8: The outputs follow any change of the inputs with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lo_bin | input | 8 | Low binary value (elapsed seconds) |
| hi_bin | input | 8 | High binary value (elapsed minutes) |
| count_down | input | 1 | 0: show as counted; 1: show time left from 2:00 |
| seg_hi_tens | output | 7 | Segments, tens digit of the high pair |
| seg_hi_units | output | 7 | Segments, units digit of the high pair |
| seg_lo_tens | output | 7 | Segments, tens digit of the low pair |
| seg_lo_units | output | 7 | Segments, units digit of the low pair |

## Verification
The block holds no state, so a fault in the reversal or in a shift-and-add-3 correction shows on the segment outputs in the same evaluation as the input that triggers it. A missing or misplaced add-3 correction appears only for certain values, most often at units digits of 5 and above or at carries into the tens digit. The bench therefore sweeps every digit and draws random values across the whole byte range. A wrong borrow in the reversal shows only at the boundary between a low input of 0 and a low input of 1, and around the overflow of each byte. Those points are driven directly.

// File: rtl/revseg_display.sv
module revseg_display #(
  parameter int START_MIN   = 2,
  parameter int SEC_PER_MIN = 60
) (
  input  logic [7:0] lo_bin,
  input  logic [7:0] hi_bin,
  input  logic       count_down,
  output logic [6:0] seg_hi_tens,
  output logic [6:0] seg_hi_units,
  output logic [6:0] seg_lo_tens,
  output logic [6:0] seg_lo_units
);

  localparam logic [7:0] START_HI = 8'(START_MIN);
  localparam logic [7:0] SEC_WRAP = 8'(SEC_PER_MIN);
  localparam logic [6:0] DASH     = 7'b0111111;

  function automatic logic [11:0] dabble(input logic [7:0] b);
    logic [19:0] s;
    s = {12'd0, b};
    for (int i = 0; i < 8; i++) begin
      if (s[11:8]  >= 4'd5) s[11:8]  = s[11:8]  + 4'd3;
      if (s[15:12] >= 4'd5) s[15:12] = s[15:12] + 4'd3;
      if (s[19:16] >= 4'd5) s[19:16] = s[19:16] + 4'd3;
      s = s << 1;
    end
    return s[19:8];
  endfunction

  function automatic logic [6:0] seg_of(input logic [3:0] d);
    case (d)
      4'd0: seg_of = 7'b1000000;
      4'd1: seg_of = 7'b1111001;
      4'd2: seg_of = 7'b0100100;
      4'd3: seg_of = 7'b0110000;
      4'd4: seg_of = 7'b0011001;
      4'd5: seg_of = 7'b0010010;
      4'd6: seg_of = 7'b0000010;
      4'd7: seg_of = 7'b1111000;
      4'd8: seg_of = 7'b0000000;
      4'd9: seg_of = 7'b0010000;
      default: seg_of = 7'b1111111;
    endcase
  endfunction

  logic       lo_zero;
  logic [7:0] lo_rev, hi_rev;
  logic [11:0] lo_bcd, hi_bcd;

  assign lo_zero = (lo_bin == 8'd0);
  assign lo_rev  = !count_down ? lo_bin : (lo_zero ? 8'd0 : SEC_WRAP - lo_bin);
  assign hi_rev  = !count_down ? hi_bin : ((lo_zero ? START_HI : START_HI - 8'd1) - hi_bin);

  assign lo_bcd = dabble(lo_rev);
  assign hi_bcd = dabble(hi_rev);

  assign seg_lo_tens  = (lo_bcd[11:8] != 4'd0) ? DASH : seg_of(lo_bcd[7:4]);
  assign seg_lo_units = (lo_bcd[11:8] != 4'd0) ? DASH : seg_of(lo_bcd[3:0]);
  assign seg_hi_tens  = (hi_bcd[11:8] != 4'd0) ? DASH : seg_of(hi_bcd[7:4]);
  assign seg_hi_units = (hi_bcd[11:8] != 4'd0) ? DASH : seg_of(hi_bcd[3:0]);

  function automatic logic legal(input logic [6:0] s);
    legal = (s == DASH);
    for (int d = 0; d < 10; d++) if (s == seg_of(4'(d))) legal = 1'b1;
  endfunction

  always_comb begin
    p_legal_code_r6: assert (legal(seg_hi_tens) && legal(seg_hi_units) &&
                             legal(seg_lo_tens) && legal(seg_lo_units));
    p_dash_pair_r5: assert (((seg_lo_tens == DASH) == (seg_lo_units == DASH)) &&
                            ((seg_hi_tens == DASH) == (seg_hi_units == DASH)));
    if (!count_down && lo_bin <= 8'd99)
      p_up_units_r1: assert (seg_lo_units == seg_of(4'(lo_bin % 8'd10)) &&
                             seg_lo_tens == seg_of(4'(lo_bin / 8'd10)));
    if (count_down && lo_zero)
      p_lo_zero_r2: assert (seg_lo_tens == 7'b1000000 && seg_lo_units == 7'b1000000);
    if (count_down && lo_zero && hi_bin == 8'd0)
      p_start_reads_0200_r4: assert (seg_hi_tens == 7'b1000000 && seg_hi_units == 7'b0100100);
  end

endmodule

// File: tb/tb_revseg_display.sv
module tb_revseg_display;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] lo_bin, hi_bin;
  logic       count_down;
  logic [6:0] seg_hi_tens, seg_hi_units, seg_lo_tens, seg_lo_units;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  revseg_display dut (
    .lo_bin(lo_bin), .hi_bin(hi_bin), .count_down(count_down),
    .seg_hi_tens(seg_hi_tens), .seg_hi_units(seg_hi_units),
    .seg_lo_tens(seg_lo_tens), .seg_lo_units(seg_lo_units)
  );

  function automatic logic [6:0] want_seg(input int d);
    logic [6:0] t [10] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19,
                           7'h12, 7'h02, 7'h78, 7'h00, 7'h10};
    return t[d];
  endfunction

  function automatic logic [13:0] want_pair(input logic [7:0] v);
    if (v > 8'd99) return {7'b0111111, 7'b0111111};
    return {want_seg(int'(v) / 10), want_seg(int'(v) % 10)};
  endfunction

  task automatic apply(input logic [7:0] h, input logic [7:0] l, input logic m, input string req);
    logic [7:0] eh, el;
    logic [27:0] exp_v, act_v;
    @(posedge clk);
    hi_bin = h; lo_bin = l; count_down = m;
    @(negedge clk);
    if (!m) begin eh = h; el = l; end
    else if (l == 8'd0) begin eh = 8'd2 - h; el = 8'd0; end
    else begin eh = 8'd1 - h; el = 8'd60 - l; end
    exp_v = {want_pair(eh), want_pair(el)};
    act_v = {seg_hi_tens, seg_hi_units, seg_lo_tens, seg_lo_units};
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s hi=%0d lo=%0d mode=%0b actual=%h expected=%h", req, h, l, m, act_v, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    hi_bin = 8'd0; lo_bin = 8'd0; count_down = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    seed = $urandom(32'd1357);
    apply(8'd0, 8'd0, 1'b0, "R1 reset state 00.00");
    apply(8'd99, 8'd99, 1'b0, "R1");
    apply(8'd7, 8'd3, 1'b0, "R7 leading zero");
    apply(8'd100, 8'd42, 1'b0, "R5 high pair over 99");
    apply(8'd12, 8'd255, 1'b0, "R5 low pair over 99");
    apply(8'd0, 8'd0, 1'b1, "R4 countdown start 02.00");
    apply(8'd1, 8'd0, 1'b1, "R2");
    apply(8'd2, 8'd0, 1'b1, "R2 end of count");
    apply(8'd0, 8'd1, 1'b1, "R3 borrow");
    apply(8'd1, 8'd59, 1'b1, "R3");
    apply(8'd2, 8'd1, 1'b1, "R5 high wraps");
    apply(8'd0, 8'd70, 1'b1, "R5 low wraps");
    for (int d = 0; d < 10; d++) apply(8'(d * 11), 8'(d * 11), 1'b0, "R6 digit codes");
    apply(8'd5, 8'd5, 1'b1, "R8 same vector other mode");
    apply(8'd5, 8'd5, 1'b0, "R8 mode change alone");
    for (int i = 0; i < 400; i++) begin
      if (i % 2 == 0)
        apply(8'($urandom_range(0, 2)), 8'($urandom_range(0, 59)), 1'($urandom), "R2 R3 random");
      else
        apply(8'($urandom), 8'($urandom), 1'($urandom), "R1 R5 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule